// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers a set of main interrupt request lines and a smaller set of secondary request lines and presents a single interrupt to a processor. The secondary lines are latched in a pending register of their own and gated by a secondary mask. They are then folded in fixed groups into a few shared main sources. Main requests, including the folded groups, latch into a source-pending register. When no interrupt is in service, the lowest-numbered source that is pending and not masked is promoted into a single-hot in-service register. An offset register reports the binary index of that source.

Software talks to the block over a plain register port. It has a write strobe, a 3-bit register address, write data, and a combinational read-data output. The pending and in-service registers are cleared by writing ones. The two mask registers are written directly. The `irq` output stays high while a source is in service.

Top module: `icu_cascade_top`

## Requirements
- R1: The in-service register (address 2) has at most one bit set at any time.
- R2: The offset register (address 3, read-only) returns the bit index of the set in-service bit. It reads 0 while the in-service register is empty.
- R3: Writing 1s to the source-pending register (address 0) or the in-service register (address 2) clears those bits, and writing all ones clears every bit. A main request that is still high at the time of the clear sets its pending bit again.
- R4: With the default cascade base of 28, secondary bits 0-2 feed main source 28, bits 3-5 feed 29, bits 6-8 feed 30 and bits 9-10 feed 31.
- R5: A folded main source is requested while any secondary pending bit in its group is set and unmasked. A masked secondary pending bit has no effect on source-pending.
- R6: The secondary mask (address 5) is 11 bits wide, a 1 masks its bit, and it resets to 0x7FF.
- R7: A secondary request latches into the secondary pending register (address 4). A bit stays set until software writes 1 to that bit position, and the write clears that bit alone.
- R8: The main mask (address 1, a 1 masks, reset all ones) decides which source-pending bits may be promoted.
- R9: Among the unmasked pending sources, the lowest index is promoted. Promotion happens only while the in-service register is empty, and a source that is in service is not displaced.
- R10: `irq` is high exactly when the in-service register is non-zero. After reset every register reads 0 except the two mask registers.
- R11: A main request sets its source-pending bit, and the bit stays set after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_MAIN | Main request lines, active high |
| sub_req | input | NUM_SUB | Secondary request lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt to the processor |

## Verification
A main request held high across one clock edge shows in source-pending after that edge. If it is unmasked and nothing is in service, it reaches `irq`, the in-service register and the offset after the next edge. A secondary request takes one more edge, because it passes through the secondary pending register first. A register write takes effect at the edge that samples the strobe. The bench drives inputs on falling edges and reads on falling edges after at least that many rising edges, always waiting two or three cycles before it compares. This means every check samples settled values and is never taken in the middle of an update.

// File: rtl/icu_pkg.sv
package icu_pkg;
   typedef enum logic [2:0] {
      REG_RAISED    = 3'd0,
      REG_GATE      = 3'd1,
      REG_ACTIVE    = 3'd2,
      REG_INDEX     = 3'd3,
      REG_SUBRAISED = 3'd4,
      REG_SUBGATE   = 3'd5
   } icu_reg_e;

   function automatic int grp_count(input int n_sub, input int grp_sz);
      return (n_sub + grp_sz - 1) / grp_sz;
   endfunction
endpackage

// File: rtl/icu_sub_fold.sv
module icu_sub_fold #(
   parameter int NUM_SUB = 11,
   parameter int GRP_SZ  = 3,
   parameter int NUM_GRP = icu_pkg::grp_count(NUM_SUB, GRP_SZ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SUB-1:0] sub_req,
   input  logic               clr_en,
   input  logic               msk_wr,
   input  logic [NUM_SUB-1:0] wbits,
   output logic [NUM_SUB-1:0] sub_pend,
   output logic [NUM_SUB-1:0] sub_mask,
   output logic [NUM_GRP-1:0] grp_req
);
   localparam logic [NUM_SUB-1:0] ALL_MASKED = '1;

   logic [NUM_SUB-1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_pend <= '0;
         sub_mask <= ALL_MASKED;
      end else begin
         sub_pend <= (sub_pend & ~(clr_en ? wbits : '0)) | sub_req;
         if (msk_wr) sub_mask <= wbits;
      end
   end

   assign live = sub_pend & ~sub_mask;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int LO = g * GRP_SZ;
      localparam int HI = ((LO + GRP_SZ) > NUM_SUB) ? NUM_SUB - 1 : LO + GRP_SZ - 1;
      assign grp_req[g] = |live[HI:LO];
   end
endmodule

// File: rtl/icu_src_pend.sv
module icu_src_pend #(
   parameter int NUM_MAIN = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_MAIN-1:0] req,
   input  logic                clr_en,
   input  logic [NUM_MAIN-1:0] clr_bits,
   output logic [NUM_MAIN-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(clr_en ? clr_bits : '0)) | req;
   end
endmodule

// File: rtl/icu_pick.sv
module icu_pick #(
   parameter int NUM_MAIN     = 32,
   parameter bit LOWEST_FIRST = 1'b1,
   localparam int IDX_W       = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1
) (
   input  logic [NUM_MAIN-1:0] cand,
   output logic                any,
   output logic [IDX_W-1:0]    idx
);
   assign any = |cand;

   if (LOWEST_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = NUM_MAIN - 1; i >= 0; i--)
            if (cand[i]) idx = IDX_W'(i);
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_MAIN; i++)
            if (cand[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/icu_inserv.sv
module icu_inserv #(
   parameter int NUM_MAIN = 32,
   localparam int IDX_W   = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                any,
   input  logic [IDX_W-1:0]    idx,
   input  logic                clr_en,
   input  logic [NUM_MAIN-1:0] clr_bits,
   output logic [NUM_MAIN-1:0] inserv,
   output logic [IDX_W-1:0]    offset
);
   logic [NUM_MAIN-1:0] kept;
   logic                empty;

   assign empty = (inserv == '0);
   assign kept  = inserv & ~(clr_en ? clr_bits : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inserv <= '0;
         offset <= '0;
      end else if (empty) begin
         if (any) begin
            inserv <= NUM_MAIN'(1) << idx;
            offset <= idx;
         end
      end else begin
         inserv <= kept;
         if (kept == '0) offset <= '0;
      end
   end
endmodule

// File: rtl/icu_cascade_top.sv
module icu_cascade_top #(
   parameter int NUM_MAIN     = 32,
   parameter int NUM_SUB      = 11,
   parameter int GRP_SZ       = 3,
   parameter int CASC_BASE    = 28,
   parameter int DATA_W       = 32,
   parameter bit LOWEST_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_MAIN-1:0] irq_req,
   input  logic [NUM_SUB-1:0]  sub_req,
   input  logic                wr_en,
   input  logic [2:0]          addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                irq
);
   import icu_pkg::*;

   localparam int NUM_GRP = grp_count(NUM_SUB, GRP_SZ);
   localparam int IDX_W   = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1;
   localparam logic [NUM_MAIN-1:0] MAIN_ALL = '1;

   if (NUM_MAIN > DATA_W) begin : g_bad_main
      $error("NUM_MAIN must not exceed DATA_W");
   end
   if (NUM_SUB > DATA_W) begin : g_bad_sub
      $error("NUM_SUB must not exceed DATA_W");
   end
   if (GRP_SZ < 1) begin : g_bad_grp
      $error("GRP_SZ must be at least 1");
   end
   if (CASC_BASE + NUM_GRP > NUM_MAIN) begin : g_bad_base
      $error("cascaded groups do not fit in the main sources");
   end

   logic [NUM_SUB-1:0]  sub_pend, sub_mask;
   logic [NUM_GRP-1:0]  grp_req;
   logic [NUM_MAIN-1:0] fold, main_req, src_pend, main_mask, inserv_q;
   logic [IDX_W-1:0]    pick_idx, offset_q;
   logic                pick_any;
   logic                wr_raised, wr_gate, wr_active, wr_subraised, wr_subgate;

   assign wr_raised    = wr_en && (addr == REG_RAISED);
   assign wr_gate      = wr_en && (addr == REG_GATE);
   assign wr_active    = wr_en && (addr == REG_ACTIVE);
   assign wr_subraised = wr_en && (addr == REG_SUBRAISED);
   assign wr_subgate   = wr_en && (addr == REG_SUBGATE);

   icu_sub_fold #(.NUM_SUB(NUM_SUB), .GRP_SZ(GRP_SZ), .NUM_GRP(NUM_GRP)) u_fold (
      .clk(clk), .rst_n(rst_n), .sub_req(sub_req),
      .clr_en(wr_subraised), .msk_wr(wr_subgate),
      .wbits(wdata[NUM_SUB-1:0]),
      .sub_pend(sub_pend), .sub_mask(sub_mask), .grp_req(grp_req)
   );

   for (genvar m = 0; m < NUM_MAIN; m++) begin : g_fold
      if (m >= CASC_BASE && m < CASC_BASE + NUM_GRP) begin : g_casc
         assign fold[m] = grp_req[m - CASC_BASE];
      end else begin : g_plain
         assign fold[m] = 1'b0;
      end
   end

   assign main_req = irq_req | fold;

   icu_src_pend #(.NUM_MAIN(NUM_MAIN)) u_src (
      .clk(clk), .rst_n(rst_n), .req(main_req),
      .clr_en(wr_raised), .clr_bits(wdata[NUM_MAIN-1:0]), .pend(src_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       main_mask <= MAIN_ALL;
      else if (wr_gate) main_mask <= wdata[NUM_MAIN-1:0];
   end

   icu_pick #(.NUM_MAIN(NUM_MAIN), .LOWEST_FIRST(LOWEST_FIRST)) u_pick (
      .cand(src_pend & ~main_mask), .any(pick_any), .idx(pick_idx)
   );

   icu_inserv #(.NUM_MAIN(NUM_MAIN)) u_insv (
      .clk(clk), .rst_n(rst_n), .any(pick_any), .idx(pick_idx),
      .clr_en(wr_active), .clr_bits(wdata[NUM_MAIN-1:0]),
      .inserv(inserv_q), .offset(offset_q)
   );

   assign irq = |inserv_q;

   always_comb begin
      case (addr)
         REG_RAISED:    rdata = DATA_W'(src_pend);
         REG_GATE:      rdata = DATA_W'(main_mask);
         REG_ACTIVE:    rdata = DATA_W'(inserv_q);
         REG_INDEX:     rdata = DATA_W'(offset_q);
         REG_SUBRAISED: rdata = DATA_W'(sub_pend);
         REG_SUBGATE:   rdata = DATA_W'(sub_mask);
         default:       rdata = '0;
      endcase
   end
endmodule

module icu_cascade_chk #(
   parameter int NUM_MAIN = 32,
   localparam int IDX_W   = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [2:0]          addr,
   input logic [NUM_MAIN-1:0] irq_req,
   input logic [NUM_MAIN-1:0] src_pend,
   input logic [NUM_MAIN-1:0] inserv,
   input logic [IDX_W-1:0]    offset
);
   // R1
   inserv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inserv));

   // R2
   offset_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inserv != '0) |-> inserv[offset]);

   // R11
   src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((src_pend & $past(irq_req)) == $past(irq_req)));

   // R9
   no_displace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((inserv != '0) && !(wr_en && addr == 3'd2)) |=> $stable(inserv));
endmodule

bind icu_cascade_top icu_cascade_chk #(.NUM_MAIN(NUM_MAIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .irq_req(irq_req), .src_pend(src_pend), .inserv(inserv_q), .offset(offset_q)
);

// File: tb/tb_icu_cascade_top.sv
module tb_icu_cascade_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_req = '0;
   logic [10:0] sub_req = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   icu_cascade_top dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sub_req(sub_req),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   function automatic int lowest(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return -1;
   endfunction

   initial begin
      logic [31:0] pat [6];
      pat[0] = 32'h0000_0001; pat[1] = 32'h8000_0000; pat[2] = 32'h0001_0110;
      pat[3] = 32'hF000_000A; pat[4] = 32'h00C0_0300; pat[5] = 32'h5000_0040;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R10 / R6 / R8: reset values
      check("R10 irq after reset", {31'd0, irq}, 0);
      chk_reg("R10 raised reset", 3'd0, 0);
      chk_reg("R8 gate reset", 3'd1, 32'hFFFF_FFFF);
      chk_reg("R10 active reset", 3'd2, 0);
      chk_reg("R2 index reset", 3'd3, 0);
      chk_reg("R10 subraised reset", 3'd4, 0);
      chk_reg("R6 subgate reset", 3'd5, 32'h7FF);

      // R11 / R3 / R8: every main line latches while masked, then clears
      for (int i = 0; i < 32; i++) begin
         @(negedge clk); irq_req = 32'd1 << i;
         @(negedge clk); irq_req = '0;
         wait_cyc(2);
         chk_reg("R11 latched after drop", 3'd0, 32'd1 << i);
         check("R8 masked no irq", {31'd0, irq}, 0);
         wr(3'd0, 32'd1 << i);
         chk_reg("R3 single clear", 3'd0, 0);
      end

      // R3: all-ones clear, and a live request sets again
      @(negedge clk); irq_req = 32'h0F0F_0F0F;
      @(negedge clk); irq_req = 32'h0000_0008;
      wr(3'd0, 32'hFFFF_FFFF);
      chk_reg("R3 clear all, live request wins", 3'd0, 32'h0000_0008);
      irq_req = '0;
      wr(3'd0, 32'hFFFF_FFFF);
      chk_reg("R3 clear all", 3'd0, 0);

      // R9 / R2 / R10: lowest-first promotion sweep
      for (int p = 0; p < 6; p++) begin
         logic [31:0] left;
         left = pat[p];
         @(negedge clk); irq_req = left;
         @(negedge clk); irq_req = '0;
         wr(3'd1, 32'h0);
         wait_cyc(2);
         while (left != 0) begin
            int lo;
            lo = lowest(left);
            chk_reg("R9 lowest promoted", 3'd2, 32'd1 << lo);
            chk_reg("R2 index", 3'd3, lo);
            check("R10 irq high", {31'd0, irq}, 1);
            wr(3'd0, 32'd1 << lo);
            wr(3'd2, 32'd1 << lo);
            wait_cyc(2);
            left[lo] = 1'b0;
         end
         check("R10 irq low when empty", {31'd0, irq}, 0);
         chk_reg("R2 index empty", 3'd3, 0);
         wr(3'd1, 32'hFFFF_FFFF);
      end

      // R9: a lower index does not displace the one in service
      wr(3'd1, 32'h0);
      @(negedge clk); irq_req = 32'h20;
      @(negedge clk); irq_req = '0;
      wait_cyc(2);
      chk_reg("R9 first in service", 3'd2, 32'h20);
      @(negedge clk); irq_req = 32'h4;
      @(negedge clk); irq_req = '0;
      wait_cyc(3);
      chk_reg("R9 not displaced", 3'd2, 32'h20);
      chk_reg("R11 both pending", 3'd0, 32'h24);
      wr(3'd0, 32'h20);
      wr(3'd2, 32'hFFFF_FFFF);
      wait_cyc(2);
      chk_reg("R9 next after clear", 3'd2, 32'h4);
      chk_reg("R2 next index", 3'd3, 2);
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      wait_cyc(2);
      check("R1 empty after clear all", {31'd0, irq}, 0);

      // R4 / R5 / R6 / R7: secondary sweep
      for (int i = 0; i < 11; i++) begin
         @(negedge clk); sub_req = 11'd1 << i;
         @(negedge clk); sub_req = '0;
         wait_cyc(3);
         chk_reg("R7 sub latched", 3'd4, 32'd1 << i);
         chk_reg("R5 masked sub no effect", 3'd0, 0);
         wr(3'd5, 32'h7FF & ~(32'd1 << i));
         wait_cyc(3);
         chk_reg("R4 group to main", 3'd0, 32'd1 << (28 + i / 3));
         wr(3'd5, 32'h7FF);
         wr(3'd4, 32'd1 << i);
         wr(3'd0, 32'hFFFF_FFFF);
         wait_cyc(2);
         chk_reg("R7 sub cleared", 3'd4, 0);
         chk_reg("R5 main stays clear", 3'd0, 0);
      end

      // R7: individual clear leaves the others set
      @(negedge clk); sub_req = 11'h505;
      @(negedge clk); sub_req = '0;
      wr(3'd4, 32'h004);
      chk_reg("R7 one bit cleared", 3'd4, 32'h501);
      wr(3'd4, 32'hFFFF_FFFF);

      // R4 / R9 / R2: unmasked cascade reaches irq with its main index
      wr(3'd1, 32'h0);
      wr(3'd5, 32'h0);
      @(negedge clk); sub_req = 11'h400;
      @(negedge clk); sub_req = '0;
      wait_cyc(3);
      chk_reg("R4 cascade in service", 3'd2, 32'h8000_0000);
      chk_reg("R2 cascade index", 3'd3, 31);
      check("R10 irq from cascade", {31'd0, irq}, 1);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule